// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block is a sixteen-pin bidirectional I/O port that sits between a simple register bus and a row of pads. Software, through the bus, sets each pin's direction, the level it drives, whether it acts as an open-drain output, and whether it is reserved for analog use. For every pin the block produces an output-enable and an output value for the pad. It returns the pad levels through a per-bit synchronizer followed by a readable pin register.

Open-drain pins only ever pull low. A latch value of 1 releases such a pin, and an external pull-up then supplies the high level. Pins marked analog always read as 0 on the digital path, whatever their pad level. Analog selection does not touch the output side: a pin left as an output still drives its latch level onto the pad. A pin level becomes visible in the pin register three clock edges after it appears at the pad. For that reason a read that follows a write or a direction change must wait for the path to settle.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every direction bit is 1 (input), and the latch, open-drain and analog registers are 0. Every `pad_oe` bit is 0.
- R2: A bus write (`bus_wr`=1) to address 0 (direction), 1 (latch), 2 (open-drain) or 3 (analog) loads that register at the clock edge. A read of the same address returns the register contents on `bus_rdata` after that edge. A latch read returns the latch, never the pin level.
- R3: A pin whose direction bit is 0 and whose open-drain bit is 0 has `pad_oe`=1, and `pad_out` equals its latch bit.
- R4: A pin whose direction bit is 1 has `pad_oe`=0, whatever its latch and open-drain bits hold.
- R5: An output pin whose open-drain bit is 1 drives `pad_oe`=1 with `pad_out`=0 when its latch is 0. When its latch is 1 it is released with `pad_oe`=0. Such a pin never drives a high level.
- R6: Address 4 reads the pin register. A level at `pad_in` appears there after exactly three rising clock edges: two synchronizer flops, then the register.
- R7: A pin whose analog bit is 1 reads 0 at address 4 whatever its pad level. Analog selection leaves `pad_oe` and `pad_out` unchanged.
- R8: Writes to address 4 and to addresses 5 to 7 change no register. Reads of addresses 5 to 7 return 0.
- R9: Writing 0xFF00 to the direction register makes pins 15:8 inputs and pins 7:0 outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pad_in | input | 16 | Pad levels (asynchronous) |
| pad_oe | output | 16 | Per-pin output enable |
| pad_out | output | 16 | Per-pin output value |

## Verification
Every cycle, the assertions check the following. Pad drive must follow the direction, latch and open-drain registers: inputs are released, push-pull pins copy the latch, and open-drain pins never drive high. A bus write must land in the addressed register. The pin register must equal the pad level from three edges earlier, masked by the analog selection. The bench scenarios are needed for the rest: the reset values as seen through the bus, the exact sampling cycle at which a pad change becomes readable, and the claim that writes to read-only or unused addresses leave the port untouched. They also cover the example direction split and random mixes of pad levels with pull-up-released open-drain pins.

// File: rtl/gpio_port_pkg.sv
// Package: register addresses and shared constants of the GPIO port.
// Assumes a 3-bit register address space; unused codes read as zero.
package gpio_port_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DIR = 3'd0,
        SEL_LAT = 3'd1,
        SEL_ODE = 3'd2,
        SEL_ANA = 3'd3,
        SEL_PIN = 3'd4
    } port_sel_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
// Configuration register bank and read mux of the GPIO port.
// Assumes single-cycle write strobes; reads are combinational.
module gpio_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  pin_val,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  lat_q,
    output logic [WIDTH-1:0]  ode_q,
    output logic [WIDTH-1:0]  ana_q,
    output logic [WIDTH-1:0]  rdata
);
    localparam logic [WIDTH-1:0] ALL_IN = {WIDTH{1'b1}};

    // Write decode: load the addressed register, reset to all inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= ALL_IN;
            lat_q <= '0;
            ode_q <= '0;
            ana_q <= '0;
        end else if (wr) begin
            case (addr)
                SEL_DIR: dir_q <= wdata;
                SEL_LAT: lat_q <= wdata;
                SEL_ODE: ode_q <= wdata;
                SEL_ANA: ana_q <= wdata;
                default: ;
            endcase
        end
    end

    // Read mux: register contents by address, zero for unused codes.
    always_comb begin
        case (addr)
            SEL_DIR: rdata = dir_q;
            SEL_LAT: rdata = lat_q;
            SEL_ODE: rdata = ode_q;
            SEL_ANA: rdata = ana_q;
            SEL_PIN: rdata = pin_val;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pad_drive.sv
// Per-pin output stage: push-pull or open-drain drive from the latch.
// Assumes the pad resolves a released pin through an external pull-up.
module gpio_pad_drive #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] lat_q,
    input  logic [WIDTH-1:0] ode_q,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        // Pin drive: input releases, open-drain drives only a low level.
        always_comb begin
            if (dir_q[i]) begin
                pad_oe[i]  = 1'b0;
                pad_out[i] = 1'b0;
            end else if (ode_q[i]) begin
                pad_oe[i]  = ~lat_q[i];
                pad_out[i] = 1'b0;
            end else begin
                pad_oe[i]  = 1'b1;
                pad_out[i] = lat_q[i];
            end
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
// Input path: synchronizer chain per bit, then analog-masked pin register.
// Assumes SYNC_STAGES >= 2; pad inputs may change at any time.
module gpio_in_sync #(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    input  logic [WIDTH-1:0] ana_q,
    output logic [WIDTH-1:0] pin_q
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [WIDTH-1:0] stage [SYNC_STAGES];

    // First synchronizer flop samples the asynchronous pads.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= pad_in;
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
        // Further synchronizer flops settle metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) stage[s] <= '0;
            else        stage[s] <= stage[s-1];
        end
    end

    // Readable pin register: analog pins are forced low.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= stage[LAST] & ~ana_q;
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
// Top of the GPIO port: register bank, pad drive and input path.
// Assumes a synchronous bus on clk and asynchronous pad inputs.
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out
);
    logic [WIDTH-1:0] dir_q, lat_q, ode_q, ana_q, pin_q;

    gpio_cfg_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
        .wdata(bus_wdata), .pin_val(pin_q), .dir_q(dir_q), .lat_q(lat_q),
        .ode_q(ode_q), .ana_q(ana_q), .rdata(bus_rdata)
    );

    gpio_pad_drive #(.WIDTH(WIDTH)) u_drive (
        .dir_q(dir_q), .lat_q(lat_q), .ode_q(ode_q),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    gpio_in_sync #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .ana_q(ana_q),
        .pin_q(pin_q)
    );
endmodule

// File: rtl/gpio_port_chk.sv
// Checker for gpio_port_ctrl: pad drive rules, write landing, pin path.
// Assumes the default two-flop synchronizer (three-edge pin latency).
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  pad_in,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  pad_out,
    input logic [WIDTH-1:0]  dir_q,
    input logic [WIDTH-1:0]  lat_q,
    input logic [WIDTH-1:0]  ode_q,
    input logic [WIDTH-1:0]  ana_q,
    input logic [WIDTH-1:0]  pin_q
);
    logic [1:0] warm;

    // Counts edges since reset release, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n)           warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    p_input_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q & pad_oe) == '0);

    p_push_pull_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dir_q & ~ode_q & ~pad_oe) == '0) &&
        ((~dir_q & ~ode_q & (pad_out ^ lat_q)) == '0));

    p_od_never_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ode_q & pad_oe & pad_out) == '0);

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_DIR) |=> dir_q == $past(bus_wdata));

    p_lat_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_LAT) |=> lat_q == $past(bus_wdata));

    p_pin_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr >= SEL_PIN) |=>
        $stable(dir_q) && $stable(lat_q) && $stable(ode_q) && $stable(ana_q));

    p_pin_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> pin_q == ($past(pad_in, 3) & ~$past(ana_q)));

    p_analog_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd0) |-> (pin_q & $past(ana_q)) == '0);
endmodule

bind gpio_port_ctrl gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .dir_q(dir_q), .lat_q(lat_q), .ode_q(ode_q),
    .ana_q(ana_q), .pin_q(pin_q)
);

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata, pad_oe, pad_out, pad_in;
    logic [W-1:0] ext_lvl = '0;   // external pull-up or driver on released pins
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_lvl);

    gpio_port_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    function automatic logic [W-1:0] f_oe(logic [W-1:0] d, logic [W-1:0] l, logic [W-1:0] o);
        return ~d & ~(o & l);
    endfunction
    function automatic logic [W-1:0] f_out(logic [W-1:0] d, logic [W-1:0] l, logic [W-1:0] o);
        return ~d & ~o & l;
    endfunction
    function automatic logic [W-1:0] f_pad(logic [W-1:0] d, logic [W-1:0] l, logic [W-1:0] o, logic [W-1:0] e);
        logic [W-1:0] oe = f_oe(d, l, o);
        return (oe & f_out(d, l, o)) | (~oe & e);
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd(logic [2:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle3();
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v, d, l, o, a, prev;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        rd(3'd0, v); check("R1 dir", v, 16'hFFFF);
        rd(3'd1, v); check("R1 lat", v, 16'h0000);
        rd(3'd2, v); check("R1 ode", v, 16'h0000);
        rd(3'd3, v); check("R1 ana", v, 16'h0000);
        check("R1 pad_oe", pad_oe, 16'h0000);

        // R9 direction split, R3 push-pull, R2 latch readback
        wr(3'd1, 16'hA5C3);
        wr(3'd0, 16'hFF00);
        check("R9 pad_oe", pad_oe, 16'h00FF);
        check("R3 pad_out", pad_out, 16'h00C3);
        rd(3'd1, v); check("R2 latch readback", v, 16'hA5C3);

        // R6 exact latency on input pins
        wr(3'd0, 16'hFFFF);
        ext_lvl = 16'h0000;
        settle3();
        @(negedge clk);
        ext_lvl = 16'h5A5A;
        @(posedge clk); @(posedge clk); @(negedge clk); #1;
        rd(3'd4, v); check("R6 not yet after 2 edges", v, 16'h0000);
        @(negedge clk); #1;
        rd(3'd4, v); check("R6 visible after 3 edges", v, 16'h5A5A);

        // R5 open drain: latch 1 released, latch 0 driven low
        wr(3'd2, 16'h000F);
        wr(3'd1, 16'h0005);
        wr(3'd0, 16'h0000);
        check("R5 pad_oe", pad_oe & 16'h000F, 16'h000A);
        check("R5 pad_out", pad_out & 16'h000F, 16'h0000);
        rd(3'd1, v); check("R2 latch not pin", v, 16'h0005);

        // R7 analog pins read low; output side untouched
        wr(3'd0, 16'hFFFF); wr(3'd2, 16'h0000);
        ext_lvl = 16'hFFFF;
        wr(3'd3, 16'h0F0F);
        settle3();
        rd(3'd4, v); check("R7 analog read low", v, 16'hF0F0);
        wr(3'd0, 16'h0000); wr(3'd1, 16'h00FF);
        check("R7 analog output oe", pad_oe, 16'hFFFF);
        check("R7 analog output level", pad_out, 16'h00FF);
        wr(3'd3, 16'h0000); wr(3'd0, 16'hFFFF);
        settle3();

        // R8 writes to read-only and unused addresses ignored
        rd(3'd4, prev);
        wr(3'd4, 16'h1234); wr(3'd5, 16'hFFFF); wr(3'd7, 16'h0000);
        rd(3'd0, v); check("R8 dir kept", v, 16'hFFFF);
        rd(3'd1, v); check("R8 lat kept", v, 16'h00FF);
        rd(3'd2, v); check("R8 ode kept", v, 16'h0000);
        rd(3'd3, v); check("R8 ana kept", v, 16'h0000);
        rd(3'd4, v); check("R8 pin kept", v, prev);
        rd(3'd6, v); check("R8 unused reads zero", v, 16'h0000);

        // Random mixes (R2..R7)
        for (int i = 0; i < 60; i++) begin
            d = W'($urandom); l = W'($urandom); o = W'($urandom);
            a = W'($urandom); ext_lvl = W'($urandom);
            wr(3'd0, d); wr(3'd1, l); wr(3'd2, o); wr(3'd3, a);
            check("R4 R5 R3 rand pad_oe", pad_oe, f_oe(d, l, o));
            check("R3 R5 rand pad_out", pad_out, f_out(d, l, o));
            rd(3'd2, v); check("R2 rand ode readback", v, o);
            settle3();
            rd(3'd4, v); check("R6 R7 rand pin read", v, f_pad(d, l, o, ext_lvl) & ~a);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule